// File: doc/BRIEF.md
# Configurable Overcurrent Fault Controller

This block sits between a raw overcurrent comparator flag and the gate-drive enable of a power stage. It first synchronises the flag and filters it with one of four deglitch times. It then handles a confirmed fault under one of four run-time policies: it can hold the stage off until software clears it, turn the stage off for a fixed retry interval and then release it, report the fault while the stage keeps switching, or ignore the fault altogether.

The block has three outputs. The first is a request to put the power FETs into high impedance. The second is a fault-report flag that stays high while a fault is being handled. The third is a sticky status bit that stays set until a clear command arrives. A latched fault can also be released at the start of the next PWM input period when that option is enabled. A separate driver-off input forces high impedance at any time. Every time constant is given in nanoseconds and turned into clock cycles from the `CLK_HZ` parameter.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: A fault is confirmed once the synchronised flag has been high for N consecutive clocks. N is ceil(CLK_HZ × t). The deglitch code `deg_sel` picks t: 0 = 0.2 µs, 1 = 0.6 µs, 2 = 1.25 µs, 3 = 1.6 µs. With the flag held high from some cycle on, the fault outputs change after clock edge N+3 and not before.
- R2: If the synchronised flag drops before N clocks have passed, the count starts again from zero. A flag that is high for N−1 clocks causes no fault. A flag that is high for exactly N clocks causes one.
- R3: Policy code 2'b00 (latch) drives `hiz_req`, `fault_rpt` and `fault_status` high. They stay high until the fault is cleared.
- R4: Policy code 2'b01 (retry) drives `hiz_req` and `fault_rpt` high for exactly R clocks and then releases both. `retry_sel` 0 sets R to the 5 ms interval and 1 sets it to the 500 ms interval. `fault_status` stays high after the release.
- R5: In retry policy, if the flag is still high when the retry interval ends, deglitching starts again from zero. After N clocks with the outputs enabled, the retry sequence runs again.
- R6: Policy code 2'b10 (report) drives `fault_rpt` and `fault_status` high and leaves `hiz_req` low.
- R7: Policy code 2'b11 (ignore) leaves all three outputs low whatever the flag does.
- R8: When `cyc_clr_en` is 1, a rising edge on `pwm_in` releases a latch-policy or report-policy fault and clears `fault_status`. The edge passes through two synchroniser flops, so the outputs drop after the third clock edge. When `cyc_clr_en` is 0, PWM edges have no effect.
- R9: A `clear_cmd` high on a clock edge ends any fault state and clears `fault_status` at that edge. A newly confirmed fault on the same edge takes priority over the clear.
- R10: `drv_off` high forces `hiz_req` high in the same cycle, whatever the fault state. It does not alter `fault_rpt` or `fault_status`.
- R11: While `rst_n` is low on a clock edge, all fault state clears. `hiz_req`, `fault_rpt` and `fault_status` read 0 after reset when `drv_off` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_raw | input | 1 | Raw overcurrent comparator flag, asynchronous |
| pwm_in | input | 1 | PWM input whose rising edge marks a new period |
| policy | input | 2 | Fault policy: 00 latch, 01 retry, 10 report, 11 ignore |
| deg_sel | input | 2 | Deglitch time code |
| retry_sel | input | 1 | Retry interval code |
| cyc_clr_en | input | 1 | Enable release of latched faults on a new PWM period |
| clear_cmd | input | 1 | Fault clear command, acted on at each clock edge where it is high |
| drv_off | input | 1 | Force the power stage to high impedance |
| hiz_req | output | 1 | High-impedance request to the gate drive |
| fault_rpt | output | 1 | A fault is currently being handled |
| fault_status | output | 1 | Sticky overcurrent status |

## Verification
A flag that rises on a falling clock edge shows on the outputs exactly N+3 rising edges later. The bench samples the outputs one edge before that point and again at it, so a latency that is one cycle short or one cycle long is caught. A retry window is checked on its last held cycle and on its first released cycle. Window lengths are counted in edges from the entry edge, and the re-fault gap after a retry is N edges.

A PWM-driven release lands on the third edge after the PWM input rises, and the bench samples on both sides of that edge. A clear command takes effect at the one edge where it is high. The driver-off override is combinational, so it is sampled one nanosecond after the input changes.

// File: rtl/ocp_pkg.sv
// Shared types and helpers for the overcurrent fault controller.
// Assumes times are given in nanoseconds and the clock in hertz.
package ocp_pkg;

    typedef enum logic [1:0] {
        POL_LATCH  = 2'b00,
        POL_RETRY  = 2'b01,
        POL_REPORT = 2'b10,
        POL_IGNORE = 2'b11
    } ocp_policy_e;

    typedef enum logic [1:0] {
        ST_OK,
        ST_LATCH,
        ST_RETRY,
        ST_REPORT
    } ocp_state_e;

    // Round a time up to a whole number of clock cycles, never below 1.
    function automatic int ns_to_cycles(input longint hz, input longint ns);
        longint c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/ocp_sync2.sv
// Two-flop synchroniser for one asynchronous level.
// Assumes the input is slow compared with the clock; the output lags by two edges.
module ocp_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Sample the input twice to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ocp_deglitch.sv
// Deglitch filter. It counts consecutive cycles of a high flag and reports a hit
// once the count reaches the selected limit. Assumes every limit is at least 1.
module ocp_deglitch #(
    parameter int T0 = 10,
    parameter int T1 = 30,
    parameter int T2 = 63,
    parameter int T3 = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flag,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       hit
);
    localparam int TMAX01 = (T0 > T1) ? T0 : T1;
    localparam int TMAX23 = (T2 > T3) ? T2 : T3;
    localparam int TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
    localparam int W      = $clog2(TMAX + 1);
    localparam int LIM [4] = '{T0, T1, T2, T3};

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    // Pick the active limit.
    always_comb lim = W'(LIM[sel]);

    // Count high cycles; drop back to zero on a low flag or a restart; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !flag) cnt <= '0;
        else if (cnt < lim)             cnt <= cnt + 1'b1;
    end

    // A hit is valid only while no restart is requested.
    always_comb hit = (cnt >= lim) && !restart;

    // R1: a hit needs the flag to have been high on the previous cycle
    p_hit_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(flag));

    // R2: a low flag always empties the counter
    p_low_flag_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> (cnt == '0));
endmodule

// File: rtl/ocp_retry_timer.sv
// Retry interval timer. It counts while run is high and raises done on the last
// cycle of the selected interval. Assumes each interval is at least 1 cycle.
module ocp_retry_timer #(
    parameter int R0 = 250_000,
    parameter int R1 = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic done
);
    localparam int RMAX = (R0 > R1) ? R0 : R1;
    localparam int W    = $clog2(RMAX + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] last;

    // Index of the final cycle of the interval.
    always_comb last = sel ? W'(R1 - 1) : W'(R0 - 1);

    // Done on the last cycle of a running interval.
    always_comb done = run && (cnt >= last);

    // Advance while running; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end

    // R4: the counter never passes the longest interval
    p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(RMAX - 1));
endmodule

// File: rtl/ocp_policy_fsm.sv
// Fault policy state machine. It turns a confirmed fault into the latch, retry,
// report or ignore response and keeps the sticky status bit. Assumes the hit,
// clear and edge inputs are synchronous to clk.
module ocp_policy_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] policy,
    input  logic       clear_cmd,
    input  logic       cyc_evt,
    input  logic       timer_done,
    output logic       timer_run,
    output logic       deg_restart,
    output logic       hiz_fault,
    output logic       rpt,
    output logic       status
);
    ocp_state_e state, state_nx;
    ocp_policy_e pol;
    logic        entering;
    logic        releasing;

    always_comb pol = ocp_policy_e'(policy);

    // Next-state selection; a new fault takes priority over a clear.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OK: begin
                if (hit) begin
                    unique case (pol)
                        POL_LATCH:  state_nx = ST_LATCH;
                        POL_RETRY:  state_nx = ST_RETRY;
                        POL_REPORT: state_nx = ST_REPORT;
                        POL_IGNORE: state_nx = ST_OK;
                    endcase
                end
            end
            ST_LATCH, ST_REPORT: if (clear_cmd || cyc_evt)    state_nx = ST_OK;
            ST_RETRY:            if (clear_cmd || timer_done) state_nx = ST_OK;
        endcase
    end

    // Flags for status bookkeeping.
    always_comb begin
        entering  = (state == ST_OK) && (state_nx != ST_OK);
        releasing = clear_cmd ||
                    (cyc_evt && ((state == ST_LATCH) || (state == ST_REPORT)));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OK;
        else        state <= state_nx;
    end

    // Sticky status: set on fault entry, cleared by an explicit or PWM-period release.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (entering) status <= 1'b1;
        else if (releasing) status <= 1'b0;
    end

    // Decode the outputs from the state register.
    always_comb begin
        timer_run   = (state == ST_RETRY);
        deg_restart = (state != ST_OK);
        hiz_fault   = (state == ST_LATCH) || (state == ST_RETRY);
        rpt         = (state != ST_OK);
    end

    // R7: under the ignore policy a clear state stays clear
    p_ignore_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OK && pol == POL_IGNORE) |=> (state == ST_OK));

    // R4: the end of the retry interval releases the stage
    p_retry_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETRY && timer_done) |=> (state == ST_OK));

    // R9: status holds until a release event
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !releasing) |=> status);

    // R3: a latched fault does not leave without a clear or a PWM event
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !clear_cmd && !cyc_evt) |=> (state == ST_LATCH));
endmodule

// File: rtl/ocp_fault_ctrl.sv
// Overcurrent fault controller top. It synchronises the comparator flag and the
// PWM input, deglitches the flag, applies the fault policy and merges in the
// driver-off override. Assumes the times are in ns and the clock is CLK_HZ.
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int DEG0_NS   = 200,
    parameter int DEG1_NS   = 600,
    parameter int DEG2_NS   = 1250,
    parameter int DEG3_NS   = 1600,
    parameter int RETRY0_NS = 5_000_000,
    parameter int RETRY1_NS = 500_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_raw,
    input  logic       pwm_in,
    input  logic [1:0] policy,
    input  logic [1:0] deg_sel,
    input  logic       retry_sel,
    input  logic       cyc_clr_en,
    input  logic       clear_cmd,
    input  logic       drv_off,
    output logic       hiz_req,
    output logic       fault_rpt,
    output logic       fault_status
);
    localparam int DEG0_CYC = ns_to_cycles(CLK_HZ, DEG0_NS);
    localparam int DEG1_CYC = ns_to_cycles(CLK_HZ, DEG1_NS);
    localparam int DEG2_CYC = ns_to_cycles(CLK_HZ, DEG2_NS);
    localparam int DEG3_CYC = ns_to_cycles(CLK_HZ, DEG3_NS);
    localparam int RTY0_CYC = ns_to_cycles(CLK_HZ, RETRY0_NS);
    localparam int RTY1_CYC = ns_to_cycles(CLK_HZ, RETRY1_NS);

    logic oc_s, pwm_s, pwm_d, pwm_rise, cyc_evt;
    logic hit, timer_run, timer_done, deg_restart, hiz_fault;

    ocp_sync2 u_sync_oc  (.clk(clk), .rst_n(rst_n), .d(oc_raw), .q(oc_s));
    ocp_sync2 u_sync_pwm (.clk(clk), .rst_n(rst_n), .d(pwm_in), .q(pwm_s));

    // Delay the synchronised PWM by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_d <= 1'b0;
        else        pwm_d <= pwm_s;
    end

    // A new PWM period is a rising edge; it counts only when cycle-clear is enabled.
    always_comb begin
        pwm_rise = pwm_s && !pwm_d;
        cyc_evt  = pwm_rise && cyc_clr_en;
    end

    ocp_deglitch #(
        .T0(DEG0_CYC), .T1(DEG1_CYC), .T2(DEG2_CYC), .T3(DEG3_CYC)
    ) u_deg (
        .clk(clk), .rst_n(rst_n), .flag(oc_s), .sel(deg_sel),
        .restart(deg_restart), .hit(hit)
    );

    ocp_retry_timer #(.R0(RTY0_CYC), .R1(RTY1_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .sel(retry_sel), .done(timer_done)
    );

    ocp_policy_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .policy(policy),
        .clear_cmd(clear_cmd), .cyc_evt(cyc_evt), .timer_done(timer_done),
        .timer_run(timer_run), .deg_restart(deg_restart), .hiz_fault(hiz_fault),
        .rpt(fault_rpt), .status(fault_status)
    );

    // Driver-off forces high impedance whatever the fault state.
    always_comb hiz_req = drv_off || hiz_fault;

    // R10: driver-off always yields a high-impedance request
    p_drvoff_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |-> hiz_req);

    // R6: a report-only fault never asks for high impedance by itself
    p_report_no_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_rpt && !hiz_fault && !drv_off) |-> !hiz_req);
endmodule

// File: tb/tb_ocp_fault_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_fault_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_raw = 1'b0, pwm_in = 1'b0, retry_sel = 1'b0;
    logic cyc_clr_en = 1'b0, clear_cmd = 1'b0, drv_off = 1'b0;
    logic [1:0] policy = 2'b00, deg_sel = 2'b00;
    logic hiz_req, fault_rpt, fault_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int RTY0 = 100;   // 2000 ns at 50 MHz
    localparam int RTY1 = 300;   // 6000 ns at 50 MHz

    // Row: {policy[1:0], deg_sel[1:0], exp_hiz, exp_rpt, exp_status}
    localparam logic [6:0] VEC [6] = '{
        7'b00_00_111,   // latch
        7'b01_01_111,   // retry
        7'b10_10_011,   // report
        7'b11_11_000,   // ignore
        7'b00_11_111,   // latch, longest deglitch
        7'b10_00_011    // report, shortest deglitch
    };

    always #10 clk = ~clk;

    ocp_fault_ctrl #(.RETRY0_NS(2000), .RETRY1_NS(6000)) dut (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .pwm_in(pwm_in),
        .policy(policy), .deg_sel(deg_sel), .retry_sel(retry_sel),
        .cyc_clr_en(cyc_clr_en), .clear_cmd(clear_cmd), .drv_off(drv_off),
        .hiz_req(hiz_req), .fault_rpt(fault_rpt), .fault_status(fault_status)
    );

    function automatic int deg_cycles(input logic [1:0] code);
        int ns;
        case (code)
            2'd0: ns = 200;
            2'd1: ns = 600;
            2'd2: ns = 1250;
            default: ns = 1600;
        endcase
        return (ns * 50 + 999) / 1000;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; oc_raw = 1'b0; clear_cmd = 1'b0; drv_off = 1'b0;
        pwm_in = 1'b0; cyc_clr_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_clear();
        clear_cmd = 1'b1;
        step(1);
        clear_cmd = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        // R11: reset state
        do_reset();
        chk("R11 hiz", hiz_req, 0);
        chk("R11 rpt", fault_rpt, 0);
        chk("R11 status", fault_status, 0);

        // Table: policy response and deglitch latency (R1, R3, R4, R6, R7)
        for (int i = 0; i < 6; i++) begin
            do_reset();
            policy  = VEC[i][6:5];
            deg_sel = VEC[i][4:3];
            n = deg_cycles(VEC[i][4:3]);
            oc_raw = 1'b1;
            step(n + 2);
            chk("R1 early hiz", hiz_req, 0);
            chk("R1 early rpt", fault_rpt, 0);
            step(1);
            chk("R3/R4/R6/R7 hiz", hiz_req, VEC[i][2]);
            chk("R3/R4/R6/R7 rpt", fault_rpt, VEC[i][1]);
            chk("R3/R4/R6/R7 status", fault_status, VEC[i][0]);
            oc_raw = 1'b0;
        end

        // R2: N-1 pulse rejected, N pulse accepted
        do_reset();
        policy = 2'b00; deg_sel = 2'b00; n = deg_cycles(2'b00);
        oc_raw = 1'b1; step(n - 1); oc_raw = 1'b0;
        step(20);
        chk("R2 short pulse hiz", hiz_req, 0);
        chk("R2 short pulse status", fault_status, 0);
        oc_raw = 1'b1; step(n); oc_raw = 1'b0;
        step(3);
        chk("R2 full pulse hiz", hiz_req, 1);
        step(30);
        chk("R3 latch held", hiz_req, 1);

        // R9: clear command releases at its edge
        pulse_clear();
        chk("R9 hiz", hiz_req, 0);
        chk("R9 rpt", fault_rpt, 0);
        chk("R9 status", fault_status, 0);

        // R8: PWM edge with cycle-clear disabled, then enabled
        oc_raw = 1'b1; step(n + 3); oc_raw = 1'b0;
        chk("R8 latched", hiz_req, 1);
        pwm_in = 1'b1; step(6);
        chk("R8 disabled no effect", hiz_req, 1);
        pwm_in = 1'b0; step(4);
        cyc_clr_en = 1'b1;
        pwm_in = 1'b1; step(2);
        chk("R8 before third edge", hiz_req, 1);
        step(1);
        chk("R8 released hiz", hiz_req, 0);
        chk("R8 released status", fault_status, 0);
        pwm_in = 1'b0; cyc_clr_en = 1'b0;

        // R8 with report policy
        policy = 2'b10;
        oc_raw = 1'b1; step(n + 3); oc_raw = 1'b0;
        chk("R6 report rpt", fault_rpt, 1);
        cyc_clr_en = 1'b1; pwm_in = 1'b1; step(3);
        chk("R8 report released", fault_rpt, 0);
        pwm_in = 1'b0; cyc_clr_en = 1'b0;

        // R4: long retry interval, flag removed during it
        do_reset();
        policy = 2'b01; deg_sel = 2'b00; retry_sel = 1'b1;
        oc_raw = 1'b1; step(n + 3); oc_raw = 1'b0;
        chk("R4 entry", hiz_req, 1);
        step(RTY1 - 1);
        chk("R4 last held cycle", hiz_req, 1);
        step(1);
        chk("R4 released hiz", hiz_req, 0);
        chk("R4 released rpt", fault_rpt, 0);
        chk("R4 status sticky", fault_status, 1);
        pulse_clear();
        chk("R9 status cleared", fault_status, 0);

        // R5: short interval with flag still high
        retry_sel = 1'b0;
        oc_raw = 1'b1; step(n + 3);
        chk("R5 entry", hiz_req, 1);
        step(RTY0);
        chk("R5 released", hiz_req, 0);
        step(n);
        chk("R5 gap", hiz_req, 0);
        step(1);
        chk("R5 retried", hiz_req, 1);
        oc_raw = 1'b0;
        pulse_clear();

        // R7: ignore policy with a long fault
        policy = 2'b11;
        oc_raw = 1'b1; step(200);
        chk("R7 ignore hiz", hiz_req, 0);
        chk("R7 ignore status", fault_status, 0);
        oc_raw = 1'b0;

        // R10: driver-off is immediate and leaves status alone
        drv_off = 1'b1; #1;
        chk("R10 forced", hiz_req, 1);
        chk("R10 status untouched", fault_status, 0);
        drv_off = 1'b0; #1;
        chk("R10 released", hiz_req, 0);
        step(1);
        policy = 2'b10;
        oc_raw = 1'b1; step(n + 3); oc_raw = 1'b0;
        drv_off = 1'b1; #1;
        chk("R10 in report", hiz_req, 1);
        chk("R10 rpt kept", fault_rpt, 1);
        drv_off = 1'b0;
        step(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule